// File: doc/BRIEF.md
# Reset Source and Pin Controller

This block gathers every reset request in a small controller and turns them into one synchronous system reset. It records which source caused the most recent reset in a one-hot cause word. It also owns a shared pad that starts out as a general-purpose input and can be turned into a bidirectional reset pin. Once the pad acts as the reset pin, an outside low level on it resets the system. Every reset that is not a power-on reset then pulls the pad low for a fixed stretch of bus cycles, so that other devices on the board see the reset too.

A small state machine sequences each reset. `ST_POR` holds the system while power-on is requested. `ST_RUN` is normal operation. `ST_PULSE` counts the pin pulse. `ST_SETTLE` waits until the pad reads high again through the synchroniser. The transitions are: POR→RUN on the first edge without a power-on request; RUN→PULSE on any granted request; PULSE→SETTLE when the pulse counter expires; SETTLE→RUN once the pad reads high, or at once if the pin function is off. A power-on request forces `ST_POR` from any state. On release from a power-on or debug-forced reset, a mode pin is sampled to choose between normal start and debug start. The debug pin function comes back on after every reset until software clears it.

Top module: `rstc_top`

## Requirements
- R1: While `por_req` is high, `sys_rst` is high, `cause` reads 6'b000001 and `pin_fn_en` is 0. `sys_rst` falls at the first clock edge that sees `por_req` low.
- R2: A cycle with `pin_fn_wr`=1 and `pin_fn_wdata`=1 outside reset sets `pin_fn_en`. A write of 0 has no effect. The function survives every reset except power-on and low-voltage.
- R3: A low-voltage reset clears `pin_fn_en`, so its reset drives no pin pulse.
- R4: `cause` is one-hot, with bit 0 for power-on, 1 for low-voltage, 2 for watchdog, 3 for illegal opcode, 4 for debug-force and 5 for external pin. Each reset replaces the previous value. When requests arrive together, the lowest bit index wins.
- R5: A non-power-on reset with the pin function enabled raises `pin_drive_en` for exactly PULSE_CYC (default 34) cycles. With the function disabled, `pin_drive_en` stays 0.
- R6: With the pin function disabled, `sys_rst` lasts PULSE_CYC+1 cycles. With it enabled, `sys_rst` is held until the pad reads high through the two-stage synchroniser, which gives PULSE_CYC+3 cycles when nothing else holds the pad low.
- R7: An external low on `pin_in` causes a reset only while `pin_fn_en` is 1, and only if the synchronised level stays low for at least two consecutive cycles. A single-cycle low is ignored.
- R8: The pin pulse the block drives itself never starts a second reset.
- R9: Requests other than power-on that arrive while `sys_rst` is high are ignored. They change neither `cause` nor the reset length.
- R10: At release from a power-on or debug-forced reset, `dbg_start` takes the inverse of `mode_pin`. At release from any other reset, `dbg_start` is 0.
- R11: `dbg_pin_en` is 1 after every reset. A `dbg_pin_clr` pulse outside reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_req | input | 1 | Power-on reset request, high active |
| lvd_req | input | 1 | Low-voltage reset request |
| wdog_req | input | 1 | Watchdog timeout reset request |
| illop_req | input | 1 | Illegal-opcode reset request |
| dbgf_req | input | 1 | Debugger-forced reset request |
| pin_in | input | 1 | Level read back from the shared pad |
| pin_fn_wr | input | 1 | Write strobe for the pin-function bit |
| pin_fn_wdata | input | 1 | Value written to the pin-function bit |
| mode_pin | input | 1 | Mode-select level; low selects debug start |
| dbg_pin_clr | input | 1 | Clears the debug pin function |
| sys_rst | output | 1 | Synchronous system reset, high active |
| pin_drive_en | output | 1 | Open-drain pull-down enable for the pad |
| pin_fn_en | output | 1 | Pad acts as the reset pin |
| cause | output | 6 | One-hot cause of the last reset |
| dbg_start | output | 1 | Start in debug mode after release |
| dbg_pin_en | output | 1 | Debug pin function enabled |

## Verification
The in-line assertions check several rules on every cycle. The cause word stays one-hot, and it stays frozen while a reset is held. The pin function falls only after a low-voltage request. A pin pulse starts only from normal operation. Any release with the pin function on is preceded by a high pad level, and the debug pin function is on at every release. Exact pulse and reset lengths, the priority order, the two-cycle glitch filter, mode sampling, and the absence of a self-triggered reset show up only in the bench's directed and random scenarios. There, a pad model combines the block's own pull-down with an outside driver.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    localparam int NSRC      = 6;
    localparam int SRC_POR   = 0;
    localparam int SRC_LVD   = 1;
    localparam int SRC_WDOG  = 2;
    localparam int SRC_ILLOP = 3;
    localparam int SRC_DBGF  = 4;
    localparam int SRC_PIN   = 5;

    typedef enum logic [1:0] {
        ST_POR    = 2'd0,
        ST_RUN    = 2'd1,
        ST_PULSE  = 2'd2,
        ST_SETTLE = 2'd3
    } rstc_state_e;
endpackage

// File: rtl/rstc_pin_sync.sv
module rstc_pin_sync #(
    parameter int STAGES  = 2,
    parameter int MIN_LOW = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic pin_hi,
    output logic low_ok
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] LIM = CW'(MIN_LOW - 1);

    logic [STAGES-1:0] sh;
    logic [CW-1:0]     low_cnt;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], pin_in};
    end

    assign pin_hi = sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst || pin_hi)   low_cnt <= '0;
        else if (low_cnt < LIM) low_cnt <= low_cnt + 1'b1;
    end

    assign low_ok = !pin_hi && (low_cnt >= LIM);

    // R7
    low_filter_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(low_ok) |-> $past(!pin_hi));
endmodule

// File: rtl/rstc_prio.sv
module rstc_prio #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    logic found;
    always_comb begin
        grant = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end
    assign any = |req;
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         por,
    input  logic         load,
    input  logic [N-1:0] grant,
    output logic [N-1:0] cause
);
    localparam logic [N-1:0] POR_HOT = N'(1);

    always_ff @(posedge clk) begin
        if (por)       cause <= POR_HOT;
        else if (load) cause <= grant;
    end

    // R4
    cause_onehot_chk: assert property (@(posedge clk) disable iff (por)
        $countones(cause) == 1);
endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int PULSE_CYC   = 34,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 2
) (
    input  logic            clk,
    input  logic            por_req,
    input  logic            lvd_req,
    input  logic            wdog_req,
    input  logic            illop_req,
    input  logic            dbgf_req,
    input  logic            pin_in,
    input  logic            pin_fn_wr,
    input  logic            pin_fn_wdata,
    input  logic            mode_pin,
    input  logic            dbg_pin_clr,
    output logic            sys_rst,
    output logic            pin_drive_en,
    output logic            pin_fn_en,
    output logic [NSRC-1:0] cause,
    output logic            dbg_start,
    output logic            dbg_pin_en
);
    localparam int CNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC - 1);

    rstc_state_e      state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             pin_hi, low_ok, pin_req;
    logic [NSRC-1:0]  req_vec, grant;
    logic             any_req, enter_rst, settle_ok, release_rst, sample_mode;

    rstc_pin_sync #(.STAGES(SYNC_STAGES), .MIN_LOW(MIN_LOW)) u_sync (
        .clk    (clk),
        .rst    (por_req),
        .pin_in (pin_in),
        .pin_hi (pin_hi),
        .low_ok (low_ok)
    );

    assign pin_req = pin_fn_en && low_ok;
    assign req_vec = {pin_req, dbgf_req, illop_req, wdog_req, lvd_req, 1'b0};

    rstc_prio #(.N(NSRC)) u_prio (
        .req   (req_vec),
        .grant (grant),
        .any   (any_req)
    );

    assign enter_rst   = (state == ST_RUN) && any_req;
    assign settle_ok   = !pin_fn_en || pin_hi;
    assign release_rst = (state == ST_POR) ||
                         ((state == ST_SETTLE) && settle_ok);
    assign sample_mode = cause[SRC_POR] || cause[SRC_DBGF];

    rstc_cause #(.N(NSRC)) u_cause (
        .clk   (clk),
        .por   (por_req),
        .load  (enter_rst),
        .grant (grant),
        .cause (cause)
    );

    // state register
    always_ff @(posedge clk) begin
        if (por_req) begin
            state <= ST_POR;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_POR:    state_nx = ST_RUN;
            ST_RUN: begin
                if (any_req) begin
                    state_nx = ST_PULSE;
                    cnt_nx   = CNT_LOAD;
                end
            end
            ST_PULSE: begin
                if (cnt == '0) state_nx = ST_SETTLE;
                else           cnt_nx   = cnt - 1'b1;
            end
            ST_SETTLE: begin
                if (settle_ok) state_nx = ST_RUN;
            end
        endcase
    end

    // outputs
    always_comb begin
        sys_rst      = 1'b1;
        pin_drive_en = 1'b0;
        unique case (state)
            ST_POR:    sys_rst = 1'b1;
            ST_RUN:    sys_rst = 1'b0;
            ST_PULSE:  pin_drive_en = pin_fn_en;
            ST_SETTLE: sys_rst = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por_req)
            pin_fn_en <= 1'b0;
        else if (enter_rst && grant[SRC_LVD])
            pin_fn_en <= 1'b0;
        else if (pin_fn_wr && pin_fn_wdata && !sys_rst)
            pin_fn_en <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (por_req)               dbg_pin_en <= 1'b1;
        else if (sys_rst || enter_rst) dbg_pin_en <= 1'b1;
        else if (dbg_pin_clr)      dbg_pin_en <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (por_req)          dbg_start <= 1'b0;
        else if (release_rst) dbg_start <= sample_mode && !mode_pin;
    end

    // R2
    fn_sticky_chk: assert property (@(posedge clk) disable iff (por_req)
        $fell(pin_fn_en) |-> $past(lvd_req));

    // R5
    pulse_from_run_chk: assert property (@(posedge clk) disable iff (por_req)
        $rose(pin_drive_en) |-> $past(!sys_rst));

    // R6
    release_pad_high_chk: assert property (@(posedge clk) disable iff (por_req)
        ($fell(sys_rst) && pin_fn_en) |-> $past(pin_in, 2));

    // R9
    cause_frozen_chk: assert property (@(posedge clk) disable iff (por_req)
        (sys_rst && $past(sys_rst)) |-> $stable(cause));

    // R11
    dbg_pin_on_release_chk: assert property (@(posedge clk) disable iff (por_req)
        $fell(sys_rst) |-> dbg_pin_en);
endmodule

// File: tb/rstc_top_bench.sv
module rstc_top_bench;
    localparam int PULSE_CYC = 34;

    logic clk = 1'b0;
    logic por_req, lvd_req, wdog_req, illop_req, dbgf_req;
    logic ext_lvl, pin_in, pin_fn_wr, pin_fn_wdata, mode_pin, dbg_pin_clr;
    logic sys_rst, pin_drive_en, pin_fn_en, dbg_start, dbg_pin_en;
    logic [5:0] cause;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit fn_model = 1'b0;

    always #4 clk = ~clk;

    assign pin_in = pin_drive_en ? 1'b0 : ext_lvl;

    rstc_top #(.PULSE_CYC(PULSE_CYC)) u_rstc_top (
        .clk(clk), .por_req(por_req), .lvd_req(lvd_req), .wdog_req(wdog_req),
        .illop_req(illop_req), .dbgf_req(dbgf_req), .pin_in(pin_in),
        .pin_fn_wr(pin_fn_wr), .pin_fn_wdata(pin_fn_wdata), .mode_pin(mode_pin),
        .dbg_pin_clr(dbg_pin_clr), .sys_rst(sys_rst), .pin_drive_en(pin_drive_en),
        .pin_fn_en(pin_fn_en), .cause(cause), .dbg_start(dbg_start),
        .dbg_pin_en(dbg_pin_en)
    );

    function automatic logic [5:0] exp_cause(input int k);
        return 6'(1 << k);
    endfunction

    function automatic int exp_rlen(input bit fn, input int k);
        if (k == 1 || !fn) return PULSE_CYC + 1;
        return PULSE_CYC + 3;
    endfunction

    function automatic int exp_dlen(input bit fn, input int k);
        if (k == 1 || !fn) return 0;
        return PULSE_CYC;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_req(input int k, input logic v);
        case (k)
            1: lvd_req   = v;
            2: wdog_req  = v;
            3: illop_req = v;
            4: dbgf_req  = v;
            default: ;
        endcase
    endtask

    task automatic wait_release(output int rlen, output int dlen, input int intr);
        rlen = 0;
        dlen = 0;
        while (sys_rst && rlen < 1000) begin
            rlen++;
            if (pin_drive_en) dlen++;
            if (intr != 0 && rlen == 5) set_req(intr, 1'b1);
            if (intr != 0 && rlen == 6) set_req(intr, 1'b0);
            @(negedge clk);
        end
    endtask

    task automatic fire(input int k, input int intr, output int rlen, output int dlen);
        set_req(k, 1'b1);
        @(negedge clk);
        set_req(k, 1'b0);
        wait_release(rlen, dlen, intr);
        if (k == 1) fn_model = 1'b0;
    endtask

    task automatic write_fn(input logic v);
        pin_fn_wr = 1'b1;
        pin_fn_wdata = v;
        @(negedge clk);
        pin_fn_wr = 1'b0;
        if (v) fn_model = 1'b1;
    endtask

    task automatic do_por(input logic mode);
        por_req = 1'b1;
        mode_pin = mode;
        repeat (3) @(negedge clk);
        chk(sys_rst == 1'b1, "R1 sys_rst during por", sys_rst, 1);
        chk(cause == 6'b000001, "R1 cause during por", cause, 1);
        por_req = 1'b0;
        @(negedge clk);
        chk(sys_rst == 1'b0, "R1 release after por", sys_rst, 0);
        chk(pin_fn_en == 1'b0, "R1 pin fn after por", pin_fn_en, 0);
        chk(dbg_start == !mode, "R10 mode sample on por", dbg_start, !mode);
        fn_model = 1'b0;
    endtask

    task automatic pin_low(input int n);
        ext_lvl = 1'b0;
        repeat (n) @(negedge clk);
        ext_lvl = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int rl, dl;
        logic [5:0] c0;
        void'($urandom(32'd20240611));
        por_req = 1'b1; lvd_req = 0; wdog_req = 0; illop_req = 0; dbgf_req = 0;
        ext_lvl = 1'b1; pin_fn_wr = 0; pin_fn_wdata = 0; mode_pin = 1'b1; dbg_pin_clr = 0;
        @(negedge clk);

        // R1, R10: power-on with debug start selected
        do_por(1'b0);
        chk(dbg_pin_en == 1'b1, "R11 dbg pin after por", dbg_pin_en, 1);
        dbg_pin_clr = 1'b1; @(negedge clk); dbg_pin_clr = 1'b0;
        chk(dbg_pin_en == 1'b0, "R11 dbg pin cleared", dbg_pin_en, 0);

        // R7: pin low with function disabled is ignored
        pin_low(5);
        repeat (6) @(negedge clk);
        chk(sys_rst == 1'b0, "R7 pin ignored when fn off", sys_rst, 0);

        // R5, R6: watchdog with function disabled
        fire(2, 0, rl, dl);
        chk(rl == exp_rlen(0, 2), "R6 rst len fn off", rl, exp_rlen(0, 2));
        chk(dl == 0, "R5 no drive fn off", dl, 0);
        chk(cause == exp_cause(2), "R4 cause wdog", cause, exp_cause(2));
        chk(dbg_start == 1'b0, "R10 no mode sample on wdog", dbg_start, 0);
        chk(dbg_pin_en == 1'b1, "R11 dbg pin after wdog", dbg_pin_en, 1);

        // R2: enable, write 0 ignored
        write_fn(1'b1);
        chk(pin_fn_en == 1'b1, "R2 fn set", pin_fn_en, 1);
        write_fn(1'b0);
        fn_model = 1'b1;
        chk(pin_fn_en == 1'b1, "R2 fn write0 ignored", pin_fn_en, 1);

        // R5, R6, R8: illegal opcode with pin enabled
        fire(3, 0, rl, dl);
        chk(rl == exp_rlen(1, 3), "R6 rst len fn on", rl, exp_rlen(1, 3));
        chk(dl == PULSE_CYC, "R5 pulse len", dl, PULSE_CYC);
        chk(pin_fn_en == 1'b1, "R2 fn survives illop", pin_fn_en, 1);
        repeat (12) @(negedge clk);
        chk(sys_rst == 1'b0, "R8 no retrigger", sys_rst, 0);
        chk(cause == exp_cause(3), "R8 cause kept", cause, exp_cause(3));

        // R7: single-cycle glitch ignored
        pin_low(1);
        repeat (8) @(negedge clk);
        chk(sys_rst == 1'b0, "R7 glitch ignored", sys_rst, 0);

        // R7: two-cycle low accepted
        pin_low(2);
        rl = 0;
        while (!sys_rst && rl < 10) begin rl++; @(negedge clk); end
        chk(sys_rst == 1'b1, "R7 pin reset accepted", sys_rst, 1);
        wait_release(rl, dl, 0);
        chk(cause == exp_cause(5), "R4 cause pin", cause, exp_cause(5));

        // R9: intruding request ignored
        fire(2, 3, rl, dl);
        chk(cause == exp_cause(2), "R9 cause not replaced", cause, exp_cause(2));
        chk(rl == exp_rlen(1, 2), "R9 len unchanged", rl, exp_rlen(1, 2));

        // R4: priority of simultaneous requests
        wdog_req = 1'b1; illop_req = 1'b1; dbgf_req = 1'b1;
        @(negedge clk);
        wdog_req = 1'b0; illop_req = 1'b0; dbgf_req = 1'b0;
        wait_release(rl, dl, 0);
        chk(cause == exp_cause(2), "R4 priority wdog", cause, exp_cause(2));

        // R10: debug-force with mode low
        mode_pin = 1'b0;
        fire(4, 0, rl, dl);
        chk(dbg_start == 1'b1, "R10 dbgf samples mode", dbg_start, 1);
        mode_pin = 1'b1;

        // R3: low-voltage clears pin function
        fire(1, 0, rl, dl);
        chk(pin_fn_en == 1'b0, "R3 lvd clears fn", pin_fn_en, 0);
        chk(dl == 0, "R3 no drive on lvd", dl, 0);
        chk(cause == exp_cause(1), "R4 cause lvd", cause, exp_cause(1));

        // random mix
        for (int it = 0; it < 24; it++) begin
            int k;
            logic m;
            bit fb;
            k = 1 + int'($urandom % 4);
            m = 1'($urandom % 2);
            if (($urandom % 2) == 0) write_fn(1'b1);
            repeat (int'($urandom % 4)) @(negedge clk);
            mode_pin = m;
            fb = fn_model;
            c0 = exp_cause(k);
            fire(k, 0, rl, dl);
            chk(rl == exp_rlen(fb, k), "R6 random len", rl, exp_rlen(fb, k));
            chk(dl == exp_dlen(fb, k), "R5 random drive", dl, exp_dlen(fb, k));
            chk(cause == c0, "R4 random cause", cause, c0);
            chk(dbg_start == ((k == 4) && !m), "R10 random mode", dbg_start, (k == 4) && !m);
            chk(pin_fn_en == fn_model, "R2 random fn", pin_fn_en, fn_model);
        end

        // R1: second power-on, normal start
        do_por(1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule